// File: doc/BRIEF.md
# Memory Range Clear Engine

This block erases a span of memory by overwriting it with a fixed fill byte. Software loads a start address and an end address through a small register port. Setting the launch flag in the same write that loads the end address starts the erase. The engine widens the span outward to whole 64-byte pages: the start is aligned down and the end is rounded up. It then walks the span one 32-bit word per cycle on a simple write-only memory port. Each address it drives is a fixed base plus the byte offset inside the span.

Two status flags track an erase. Busy is set while the erase runs. Finished is set once it completes, and stays set until the next erase is launched. While busy, the engine ignores any further launch and any change to its start or end registers, so a running erase cannot be disturbed. A span that is empty after rounding completes at once, with no memory traffic.

Top module: `memclr_top`

## Requirements
- R1: After reset the start register, the end register and the status register all read 0, and `mem_we_o` is low.
- R2: The start register (offset 0x18) and the end register (offset 0x1C) each hold a 22-bit address in bits 21:0 and read back with all upper bits 0. Bit 22 of the end register is a write-only launch flag and reads 0.
- R3: The status register is at offset 0x20, with bit 0 = busy and bit 1 = finished. A write to offset 0x1C with bit 22 set launches an erase. From the cycle after that write, busy reads 1 and finished reads 0. Busy and finished are never both 1.
- R4: The first word written is at `MEM_BASE` + (start & ~63). Writes go one word per cycle at addresses that rise by 4 with no gaps. The number of cycles busy reads 1, counted from the cycle after the launch write, equals the word count plus 1.
- R5: The last word written is at `MEM_BASE` + ((end + 63) & ~63) − 4. The word count is the byte length of the rounded span divided by 4. This holds when the rounded end reaches 0x400000.
- R6: Every data word driven with `mem_we_o` high is 0x5A5A5A5A.
- R7: In the cycle after the last write, busy reads 0 and finished reads 1.
- R8: If the rounded end is not above the aligned start, no write is issued. Busy reads 1 for exactly one cycle, and then finished reads 1.
- R9: While busy is 1, writes to the start and end registers, including launch requests, change nothing. The erase in progress keeps its word count.
- R10: A write to the end register with bit 22 clear updates the address only. It starts no erase and leaves the status register unchanged.
- R11: Offsets other than 0x18, 0x1C and 0x20 read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset for reads and writes |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data (fill pattern) |

## Verification
The erase is run over several kinds of span:
- A span already on page boundaries, which fixes the baseline word count.
- Unaligned start and end, which separates aligning down from rounding up.
- An end that sits exactly on a boundary, which exposes an off-by-one in the rounding.
- A span at the top of the address field, whose rounded end overflows 22 bits.
- Equal and reversed endpoints, which must give zero writes.

For every span, the bench checks the first and last address, the data, the gaps between addresses and the length of the busy interval. A launch issued during a long erase, a plain end write without the launch flag, and unmapped offsets show whether the lockout and the decode are tight.

// File: rtl/memclr_pkg.sv
package memclr_pkg;
  localparam logic [7:0] OFF_START  = 8'h18;
  localparam logic [7:0] OFF_END    = 8'h1C;
  localparam logic [7:0] OFF_STATUS = 8'h20;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/memclr_regs.sv
module memclr_regs #(
  parameter int ADDR_W = 22,
  parameter int REG_AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              fin_i,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic [ADDR_W-1:0] end_addr_o,
  output logic              launch_o,
  output logic              pending_o,
  output logic              done_o
);
  localparam logic [REG_AW-1:0] A_START  = REG_AW'(memclr_pkg::OFF_START);
  localparam logic [REG_AW-1:0] A_END    = REG_AW'(memclr_pkg::OFF_END);
  localparam logic [REG_AW-1:0] A_STATUS = REG_AW'(memclr_pkg::OFF_STATUS);

  logic [ADDR_W-1:0] start_q, end_q;
  logic pending_q, done_q, launch_q;
  logic wr_start, wr_end, go;

  // all writes locked out while an erase runs
  assign wr_start = reg_wr_i && (reg_addr_i == A_START) && !pending_q;
  assign wr_end   = reg_wr_i && (reg_addr_i == A_END)   && !pending_q;
  assign go       = wr_end && reg_wdata_i[ADDR_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q   <= '0;
      end_q     <= '0;
      pending_q <= 1'b0;
      done_q    <= 1'b0;
      launch_q  <= 1'b0;
    end else begin
      launch_q <= go;
      if (wr_start) start_q <= reg_wdata_i[ADDR_W-1:0];
      if (wr_end)   end_q   <= reg_wdata_i[ADDR_W-1:0];
      if (go) begin
        pending_q <= 1'b1;
        done_q    <= 1'b0;
      end else if (fin_i) begin
        pending_q <= 1'b0;
        done_q    <= 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == A_START)       reg_rdata_o = 32'(start_q);
    else if (reg_addr_i == A_END)    reg_rdata_o = 32'(end_q);
    else if (reg_addr_i == A_STATUS) reg_rdata_o = {30'b0, done_q, pending_q};
  end

  assign start_addr_o = start_q;
  assign end_addr_o   = end_q;
  assign launch_o     = launch_q;
  assign pending_o    = pending_q;
  assign done_o       = done_q;

  AST_START_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && reg_wr_i && reg_addr_i == A_START) |=> (start_q == $past(start_q))); // R9
  AST_END_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && reg_wr_i && reg_addr_i == A_END) |=> (end_q == $past(end_q))); // R9
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pending_q && done_q)); // R3
endmodule

// File: rtl/memclr_range.sv
module memclr_range #(
  parameter int ADDR_W     = 22,
  parameter int PAGE_SHIFT = 6,
  parameter int WSHIFT     = 2,
  localparam int WIDX_W    = ADDR_W + 1 - WSHIFT
) (
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] end_i,
  output logic [WIDX_W-1:0] first_word_o,
  output logic [WIDX_W-1:0] stop_word_o,
  output logic              empty_o
);
  // one extra bit so the rounded end can reach 2**ADDR_W
  logic [ADDR_W:0] start_al, end_sum, end_rnd;

  assign start_al = {1'b0, start_i[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
  assign end_sum  = {1'b0, end_i} + (ADDR_W+1)'((1 << PAGE_SHIFT) - 1);
  assign end_rnd  = {end_sum[ADDR_W:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};

  assign first_word_o = start_al[ADDR_W:WSHIFT];
  assign stop_word_o  = end_rnd[ADDR_W:WSHIFT];
  assign empty_o      = (end_rnd <= start_al);
endmodule

// File: rtl/memclr_seq.sv
module memclr_seq #(
  parameter int              WIDX_W   = 21,
  parameter int              WSHIFT   = 2,
  parameter int              MEM_AW   = 32,
  parameter logic [MEM_AW-1:0] MEM_BASE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [WIDX_W-1:0] first_word_i,
  input  logic [WIDX_W-1:0] stop_word_i,
  input  logic              empty_i,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic              fin_o
);
  import memclr_pkg::*;

  seq_state_e        state_q;
  logic [WIDX_W-1:0] cur_q, stop_q;
  logic              last_word;

  assign last_word = (cur_q + WIDX_W'(1)) == stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cur_q   <= '0;
      stop_q  <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (launch_i && !empty_i) begin
          state_q <= SEQ_RUN;
          cur_q   <= first_word_i;
          stop_q  <= stop_word_i;
        end
        SEQ_RUN: begin
          cur_q <= cur_q + WIDX_W'(1);
          if (last_word) state_q <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign mem_we_o   = (state_q == SEQ_RUN);
  assign mem_addr_o = MEM_BASE + MEM_AW'({cur_q, {WSHIFT{1'b0}}});
  assign fin_o      = ((state_q == SEQ_IDLE) && launch_i && empty_i) ||
                      ((state_q == SEQ_RUN) && last_word);

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) + MEM_AW'(1 << WSHIFT))); // R4
  AST_CUR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_RUN) |-> (cur_q < stop_q)); // R5
  AST_LAUNCH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> (state_q == SEQ_IDLE)); // R9
endmodule

// File: rtl/memclr_top.sv
module memclr_top #(
  parameter int              ADDR_W     = 22,
  parameter int              REG_AW     = 6,
  parameter int              PAGE_BYTES = 64,
  parameter int              WORD_BYTES = 4,
  parameter int              MEM_AW     = 32,
  parameter logic [MEM_AW-1:0] MEM_BASE = 32'h2000_0000,
  parameter logic [7:0]      FILL_BYTE  = 8'h5A,
  localparam int             DATA_W     = 8 * WORD_BYTES,
  localparam int             PAGE_SHIFT = $clog2(PAGE_BYTES),
  localparam int             WSHIFT     = $clog2(WORD_BYTES),
  localparam int             WIDX_W     = ADDR_W + 1 - WSHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  logic [ADDR_W-1:0] start_addr, end_addr;
  logic [WIDX_W-1:0] first_word, stop_word;
  logic launch, pending, done, fin, empty;

  memclr_regs #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_regs (
    .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .fin_i(fin), .start_addr_o(start_addr), .end_addr_o(end_addr),
    .launch_o(launch), .pending_o(pending), .done_o(done)
  );

  memclr_range #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .WSHIFT(WSHIFT)) u_range (
    .start_i(start_addr), .end_i(end_addr),
    .first_word_o(first_word), .stop_word_o(stop_word), .empty_o(empty)
  );

  memclr_seq #(.WIDX_W(WIDX_W), .WSHIFT(WSHIFT), .MEM_AW(MEM_AW), .MEM_BASE(MEM_BASE)) u_seq (
    .clk_i, .rst_ni, .launch_i(launch), .first_word_i(first_word),
    .stop_word_i(stop_word), .empty_i(empty),
    .mem_we_o, .mem_addr_o, .fin_o(fin)
  );

  assign mem_wdata_o = {WORD_BYTES{FILL_BYTE}};

  AST_WE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> pending); // R4
  AST_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pending) |-> done); // R7
  AST_FIN_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin |-> pending); // R8
endmodule

// File: tb/memclr_top_tb_top.sv
module memclr_top_tb_top;
  localparam logic [31:0] BASE  = 32'h2000_0000;
  localparam logic [5:0]  A_ST  = 6'h18;
  localparam logic [5:0]  A_EN  = 6'h1C;
  localparam logic [5:0]  A_SS  = 6'h20;
  localparam logic [31:0] GO    = 32'h0040_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_we;
  logic [31:0] mem_addr, mem_wdata;

  int checks = 0, failures = 0;
  int wr_cnt = 0, gap_err = 0, data_err = 0;
  logic [31:0] first_addr = '0, last_addr = '0;
  logic prev_we = 1'b0;

  always #2.5 clk = ~clk;

  memclr_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata)
  );

  // memory-side monitor
  always @(posedge clk) begin
    if (mem_we) begin
      if (!prev_we) first_addr = mem_addr;
      else if (mem_addr != last_addr + 32'd4) gap_err = gap_err + 1;
      if (mem_wdata != 32'h5A5A5A5A) data_err = data_err + 1;
      last_addr = mem_addr;
      wr_cnt = wr_cnt + 1;
    end
    prev_we = mem_we;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      reg_read(A_SS, s);
      if (!s[0]) break;
      @(negedge clk);
    end
  endtask

  // full erase with exact expectations
  task automatic run_clear(input string req, input logic [21:0] st, input logic [21:0] en);
    logic [22:0] s_al, e_rnd;
    int words, cyc, base_cnt, gerr0, derr0;
    logic [31:0] s;
    s_al  = {1'b0, st[21:6], 6'b0};
    e_rnd = ({1'b0, en} + 23'd63) & ~23'd63;
    words = (e_rnd > s_al) ? int'((e_rnd - s_al) >> 2) : 0;
    reg_write(A_ST, 32'(st));
    base_cnt = wr_cnt; gerr0 = gap_err; derr0 = data_err;
    reg_write(A_EN, GO | 32'(en));
    reg_read(A_SS, s);
    check(s[1:0] == 2'b01, {req, " R3 busy after launch"}, s, 32'h1);
    cyc = 1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      reg_read(A_SS, s);
      if (!s[0]) break;
      cyc++;
    end
    check(s[1:0] == 2'b10, {req, " R7 finished"}, s, 32'h2);
    check(cyc == words + 1, {req, " R4 busy cycles"}, cyc, words + 1);
    check(wr_cnt - base_cnt == words, {req, " R5 word count"}, wr_cnt - base_cnt, words);
    check(gap_err == gerr0, {req, " R4 contiguous"}, gap_err, gerr0);
    check(data_err == derr0, {req, " R6 fill data"}, data_err, derr0);
    if (words > 0) begin
      check(first_addr == BASE + 32'(s_al), {req, " R4 first addr"}, first_addr, BASE + 32'(s_al));
      check(last_addr == BASE + 32'(e_rnd) - 32'd4, {req, " R5 last addr"}, last_addr, BASE + 32'(e_rnd) - 32'd4);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_read(A_ST, d); check(d == 0, "R1 start reset", d, 0);
    reg_read(A_EN, d); check(d == 0, "R1 end reset", d, 0);
    reg_read(A_SS, d); check(d == 0, "R1 status reset", d, 0);
    check(mem_we == 1'b0, "R1 we reset", 32'(mem_we), 0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    reg_write(A_ST, 32'hFFFF_FFFF & ~GO);
    reg_read(A_ST, d); check(d == 32'h003F_FFFF, "R2 start mask", d, 32'h003F_FFFF);
    reg_write(A_EN, 32'hFF80_1234);
    reg_read(A_EN, d); check(d == 32'h0000_1234, "R2 end mask", d, 32'h0000_1234);
  endtask

  task automatic t_empty();
    run_clear("R8 equal", 22'h80, 22'h80);
    run_clear("R8 reversed", 22'h400, 22'h100);
  endtask

  task automatic t_locked();
    logic [31:0] d;
    int c0;
    reg_write(A_ST, 32'h0);
    c0 = wr_cnt;
    reg_write(A_EN, GO | 32'hFF);
    reg_write(A_EN, GO | 32'h3000);
    reg_write(A_ST, 32'h1000);
    wait_idle();
    repeat (5) @(negedge clk);
    check(wr_cnt - c0 == 64, "R9 count kept", wr_cnt - c0, 64);
    reg_read(A_ST, d); check(d == 0, "R9 start kept", d, 0);
    reg_read(A_EN, d); check(d == 32'hFF, "R9 end kept", d, 32'hFF);
  endtask

  task automatic t_no_valid();
    logic [31:0] d;
    int c0;
    c0 = wr_cnt;
    reg_write(A_EN, 32'h200);
    repeat (6) @(negedge clk);
    reg_read(A_SS, d); check(d == 32'h2, "R10 status unchanged", d, 32'h2);
    check(wr_cnt == c0, "R10 no writes", wr_cnt - c0, 0);
    reg_read(A_EN, d); check(d == 32'h200, "R10 end updated", d, 32'h200);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    int c0;
    c0 = wr_cnt;
    reg_write(6'h04, 32'hFFFF_FFFF);
    reg_write(6'h24, GO | 32'h40);
    repeat (4) @(negedge clk);
    reg_read(6'h04, d); check(d == 0, "R11 read zero", d, 0);
    reg_read(6'h3C, d); check(d == 0, "R11 read zero hi", d, 0);
    reg_read(A_SS, d); check(d == 32'h2, "R11 no launch", d, 32'h2);
    reg_read(A_ST, d); check(d == 0, "R11 start untouched", d, 0);
    check(wr_cnt == c0, "R11 no writes", wr_cnt - c0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    run_clear("aligned", 22'h100, 22'h140);
    run_clear("unaligned", 22'h13, 22'h81);
    run_clear("exact end", 22'h0, 22'h40);
    run_clear("top", 22'h3FFFC5, 22'h3FFFF0);
    t_empty();
    t_locked();
    t_no_valid();
    t_unmapped();
    run_clear("relaunch", 22'h7C0, 22'h801);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule